// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Array

This block is a synthesizable, cycle-level model of a tiny dynamic memory device. It holds sixteen one-bit cells in a four-by-four grid. A location is presented over a two-pin address port in two halves. The row half is taken when the row strobe goes low. The column half is taken when the column strobe goes low while that row is open. All strobes are sampled on the system clock, and a strobe edge is a change between two consecutive samples.

Opening a row copies every cell of that row into a bank of per-column sense latches, and the latches hold the row's charge for as long as the row stays open. Reads are served from the latch picked by the column half. Writes go into that latch and the cell behind it. Each cell has its own retention counter. A cell that goes a full retention interval without a row activation loses its bit to 0, and its decay flag is raised so that missed refresh can be seen from outside. A two-bit reference-select output shows which reference row the sense latches are compared against.

Top module: `dram_mux_array`

## Requirements
- R1: While reset is applied and just after it is released: `dout` is 0, `row_open` is 0, `ref_sel` is 2'b00, every decay flag is 0, and every cell reads back as 0.
- R2: When `ras_n` goes from 1 to 0, `addr` is taken as the row number (location bits 3:2) and `row_open` is 1 from the next cycle. When `cas_n` then goes from 1 to 0, `addr` is taken as the column (location bits 1:0). The location is row*4 + column.
- R3: Activating a row loads all four cells of that row into the sense latches. Several column strobes within one open-row period can read or write any column of that row.
- R4: Every cell of an activated row has its retention interval restarted when the row opens, and the interval stays restarted for as long as the row is open. This holds for all cells of the row, not only the cell that was accessed.
- R5: A cell whose row has not been open for RET_CYCLES clock cycles drops its bit to 0 and sets its flag in `decayed` (bit index row*4 + column). The flag clears the next time its row is activated. No flag is set earlier than the retention interval.
- R6: While a row is open, `ref_sel` is 2'b10 (reference B) for rows 0 and 1 and 2'b01 (reference A) for rows 2 and 3. It is 2'b00 while no row is open.
- R7: A column strobe with `we_n` = 1 updates `dout` at that clock edge to the stored bit of the addressed location.
- R8: A column strobe with `we_n` = 0 stores `din` into the addressed sense latch and cell. `dout` is not changed, and later reads return the stored bit.
- R9: A falling `cas_n` while `ras_n` is high is ignored: `dout` and the contents of every cell are left unchanged.
- R10: When `ras_n` goes from 0 to 1, the row closes, and `row_open` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Multiplexed address pins: row half, then column half |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write select, sampled with the column strobe |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, held between reads |
| row_open | output | 1 | High while a row is activated |
| ref_sel | output | 2 | Reference row select: 2'b01 = A, 2'b10 = B, 2'b00 = none |
| decayed | output | 2**(2*ADDR_W) | Per-cell flag: the bit was lost because a refresh was missed |

## Verification
The core function is tested in three ways. Single accesses that open a row, strobe one column and close the row are run over scattered locations in every row, with a later write over an earlier one; this separates the row half from the column half and catches a swapped nibble. Page-mode bursts run four column strobes inside one row activation, mixing a write with reads of the other columns; this shows that the whole row was sensed and that the write reached its latch. Retention runs leave rows untouched past the interval while one row is reactivated, which separates a row-wide restore from a restore of the accessed cell only. A final read then confirms that lost bits read back as 0.

// File: rtl/dram_pkg.sv
package dram_pkg;

  // Reference row selection, one-hot, none while idle.
  typedef enum logic [1:0] {
    REF_NONE = 2'b00,
    REF_A    = 2'b01,
    REF_B    = 2'b10
  } ref_sel_e;

  // The reference row always sits across the sense latches from the
  // data row: lower half of the rows uses B, upper half uses A.
  function automatic ref_sel_e ref_for_row(input logic upper_half);
    return upper_half ? REF_A : REF_B;
  endfunction

endpackage

// File: rtl/dram_strobe_sync.sv
// Samples both active-low strobes and produces single-cycle edge pulses.
module dram_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  output logic ras_fall,
  output logic ras_rise,
  output logic cas_fall
);

  localparam int NSTROBE = 2;

  logic [NSTROBE-1:0] cur;
  logic [NSTROBE-1:0] prev_q;
  logic [NSTROBE-1:0] fall;

  assign cur = {cas_n, ras_n};

  for (genvar s = 0; s < NSTROBE; s++) begin : g_strobe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[s] <= 1'b1;
      end else begin
        prev_q[s] <= cur[s];
      end
    end
    assign fall[s] = prev_q[s] & ~cur[s];
  end

  assign ras_fall = fall[0];
  assign cas_fall = fall[1];
  assign ras_rise = ~prev_q[0] & cur[0];

endmodule

// File: rtl/dram_cell_bank.sv
// Storage cells with one retention counter per cell.
module dram_cell_bank #(
  parameter int ROWS       = 4,
  parameter int COLS       = 4,
  parameter int RET_CYCLES = 1024,
  localparam int ROW_W     = $clog2(ROWS),
  localparam int COL_W     = $clog2(COLS),
  localparam int CELLS     = ROWS * COLS,
  localparam int CNT_W     = $clog2(RET_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROWS-1:0]  restore_rows,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [COL_W-1:0] wr_col,
  input  logic             wr_bit,
  output logic [CELLS-1:0] cell_bits,
  output logic [CELLS-1:0] decayed
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;

      logic [CNT_W-1:0] cnt_q, cnt_d;
      logic             bit_q, bit_d;
      logic             dec_q, dec_d;
      logic             wr_hit;
      logic             en;

      assign wr_hit = wr_en && (wr_row == ROW_W'(r)) && (wr_col == COL_W'(c));
      assign en     = restore_rows[r] || (cnt_q != '0);

      always_comb begin
        cnt_d = cnt_q;
        bit_d = bit_q;
        dec_d = dec_q;
        if (restore_rows[r]) begin
          cnt_d = CNT_W'(RET_CYCLES);
          dec_d = 1'b0;
          if (wr_hit) begin
            bit_d = wr_bit;
          end
        end else if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) begin
            bit_d = 1'b0;
            dec_d = 1'b1;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= CNT_W'(RET_CYCLES);
          bit_q <= 1'b0;
          dec_q <= 1'b0;
        end else if (en) begin
          cnt_q <= cnt_d;
          bit_q <= bit_d;
          dec_q <= dec_d;
        end
      end

      assign cell_bits[IDX] = bit_q;
      assign decayed[IDX]   = dec_q;
    end
  end

endmodule

// File: rtl/dram_sense_row.sv
// Per-column sense latches and the column read multiplexer.
module dram_sense_row #(
  parameter int COLS   = 4,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [COLS-1:0]  load_bits,
  input  logic             wr_en,
  input  logic [COL_W-1:0] wr_col,
  input  logic             wr_bit,
  input  logic [COL_W-1:0] col_sel,
  output logic             rd_bit
);

  logic [COLS-1:0] latch_q, latch_d;
  logic            en;

  assign en = load_en | wr_en;

  always_comb begin
    latch_d = latch_q;
    if (load_en) begin
      latch_d = load_bits;
    end else if (wr_en) begin
      latch_d[wr_col] = wr_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (en) begin
      latch_q <= latch_d;
    end
  end

  assign rd_bit = latch_q[col_sel];

endmodule

// File: rtl/dram_mux_array.sv
module dram_mux_array #(
  parameter int ADDR_W     = 2,
  parameter int RET_CYCLES = 1024,
  localparam int ROWS      = 1 << ADDR_W,
  localparam int COLS      = 1 << ADDR_W,
  localparam int CELLS     = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              din,
  output logic              dout,
  output logic              row_open,
  output logic [1:0]        ref_sel,
  output logic [CELLS-1:0]  decayed
);
  import dram_pkg::*;

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic ras_fall, ras_rise, cas_fall;

  dram_strobe_sync u_strobe (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .ras_fall (ras_fall),
    .ras_rise (ras_rise),
    .cas_fall (cas_fall)
  );

  // Row state.
  logic              open_q, open_d;
  logic [ADDR_W-1:0] row_q, row_d;
  logic              row_en;

  always_comb begin
    open_d = open_q;
    row_d  = row_q;
    if (ras_fall) begin
      open_d = 1'b1;
      row_d  = addr;
    end else if (ras_rise) begin
      open_d = 1'b0;
    end
  end
  assign row_en = ras_fall | ras_rise;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (row_en) begin
      open_q <= open_d;
      row_q  <= row_d;
    end
  end

  // Column access, valid only with the row strobe low and a row open.
  logic access, wr_acc, rd_acc;
  assign access = cas_fall & ~ras_n & open_q;
  assign wr_acc = access & ~we_n;
  assign rd_acc = access & we_n;

  // Rows being restored this cycle: the one opening and the one held open.
  logic [ROWS-1:0] restore_rows;
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      restore_rows[r] = (ras_fall && (addr == ADDR_W'(r))) ||
                        (open_q && (row_q == ADDR_W'(r)));
    end
  end

  logic [CELLS-1:0] cell_bits;

  dram_cell_bank #(
    .ROWS       (ROWS),
    .COLS       (COLS),
    .RET_CYCLES (RET_CYCLES)
  ) u_cells (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .restore_rows (restore_rows),
    .wr_en        (wr_acc),
    .wr_row       (row_q),
    .wr_col       (addr),
    .wr_bit       (din),
    .cell_bits    (cell_bits),
    .decayed      (decayed)
  );

  logic [COLS-1:0] row_bits;
  logic            rd_bit;

  assign row_bits = cell_bits[int'(addr) * COLS +: COLS];

  dram_sense_row #(
    .COLS (COLS)
  ) u_sense (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_en   (ras_fall),
    .load_bits (row_bits),
    .wr_en     (wr_acc),
    .wr_col    (addr),
    .wr_bit    (din),
    .col_sel   (addr),
    .rd_bit    (rd_bit)
  );

  // Output data register, loaded on reads only.
  logic dout_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dout_q <= 1'b0;
    end else if (rd_acc) begin
      dout_q <= rd_bit;
    end
  end

  ref_sel_e ref_now;
  assign ref_now  = open_q ? ref_for_row(row_q[ADDR_W-1]) : REF_NONE;
  assign ref_sel  = ref_now;
  assign dout     = dout_q;
  assign row_open = open_q;

endmodule

// File: rtl/dram_mux_array_chk.sv
module dram_mux_array_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       dout,
  input logic       row_open,
  input logic [1:0] ref_sel
);

  // R2: a sampled row-strobe fall opens a row on the next cycle.
  a_r2_row_opens: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |=> row_open);

  // R10: a sampled row-strobe rise closes the row on the next cycle.
  a_r10_row_closes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> !row_open);

  // R6: at most one reference row is selected.
  a_r6_ref_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ref_sel));

  // R6: no reference row is selected while the array is idle.
  a_r6_ref_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !row_open |-> (ref_sel == 2'b00));

  // R9: a column strobe with the row strobe high leaves the data output alone.
  a_r9_cas_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && ras_n) |=> $stable(dout));

endmodule

bind dram_mux_array dram_mux_array_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .dout     (dout),
  .row_open (row_open),
  .ref_sel  (ref_sel)
);

// File: tb/sim_dram_mux_array.sv
`timescale 1ns/1ps
module sim_dram_mux_array;

  localparam int RET = 400;

  logic        clk;
  logic        rst_n;
  logic [1:0]  addr;
  logic        ras_n, cas_n, we_n, din;
  logic        dout, row_open;
  logic [1:0]  ref_sel;
  logic [15:0] decayed;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic mem [16];

  dram_mux_array #(.ADDR_W(2), .RET_CYCLES(RET)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .din(din), .dout(dout), .row_open(row_open),
    .ref_sel(ref_sel), .decayed(decayed)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector: {write, location[3:0], data}; reads compare with the shadow.
  localparam logic [5:0] VEC [12] = '{
    6'b1_0100_1, 6'b1_0111_1, 6'b1_1001_1, 6'b1_1110_1,
    6'b1_0011_1, 6'b0_0100_0, 6'b0_0101_0, 6'b0_1001_0,
    6'b0_1110_0, 6'b1_0100_0, 6'b0_0100_0, 6'b0_0011_0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic activate(input logic [1:0] row);
    addr  = row;
    ras_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic cas_op(input logic [1:0] col, input logic wr, input logic d,
                        output logic q);
    addr  = col;
    we_n  = ~wr;
    din   = d;
    cas_n = 1'b0;
    @(negedge clk);
    q     = dout;
    cas_n = 1'b1;
    we_n  = 1'b1;
    @(negedge clk);
  endtask

  task automatic precharge();
    ras_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic access(input logic [3:0] loc, input logic wr, input logic d,
                        output logic q);
    activate(loc[3:2]);
    cas_op(loc[1:0], wr, d, q);
    precharge();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic q, prev;
    rst_n = 1'b0; addr = '0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; din = 1'b0;
    for (int i = 0; i < 16; i++) mem[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk("R1 dout in reset", dout, 0);
    chk("R1 row_open in reset", row_open, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ref_sel after reset", ref_sel, 0);
    chk("R1 decayed after reset", decayed, 0);
    access(4'd10, 1'b0, 1'b0, q);
    chk("R1 cell 10 reads 0", q, 0);

    // R2 R7 R8: vector walk over single accesses
    for (int i = 0; i < 12; i++) begin
      logic [5:0] v;
      v = VEC[i];
      access(v[4:1], v[5], v[0], q);
      if (v[5]) mem[v[4:1]] = v[0];
      else chk($sformatf("R7 R2 read loc %0d", v[4:1]), q, mem[v[4:1]]);
    end

    // R8: a write leaves dout unchanged
    prev = dout;
    access(4'd2, 1'b1, ~prev, q);
    mem[2] = ~prev;
    chk("R8 dout held on write", q, prev);

    // R6 R2 R10: reference selection and row state
    activate(2'd1);
    chk("R2 row open", row_open, 1);
    chk("R6 row 1 uses ref B", ref_sel, 2'b10);
    precharge();
    chk("R10 row closed", row_open, 0);
    chk("R6 idle no ref", ref_sel, 2'b00);
    activate(2'd2);
    chk("R6 row 2 uses ref A", ref_sel, 2'b01);
    precharge();
    activate(2'd0);
    chk("R6 row 0 uses ref B", ref_sel, 2'b10);
    precharge();
    activate(2'd3);
    chk("R6 row 3 uses ref A", ref_sel, 2'b01);
    precharge();

    // R3: page mode within one activation of row 1
    activate(2'd1);
    cas_op(2'd2, 1'b1, 1'b1, q);
    mem[6] = 1'b1;
    for (int c = 0; c < 4; c++) begin
      cas_op(c[1:0], 1'b0, 1'b0, q);
      chk($sformatf("R3 page read col %0d", c), q, mem[4 + c]);
    end
    precharge();

    // R9: column strobe with row strobe high is ignored
    prev = dout;
    cas_op(2'd0, 1'b1, 1'b1, q);
    chk("R9 dout unchanged", dout, prev);
    access(4'd0, 1'b0, 1'b0, q);
    chk("R9 cell 0 untouched", q, mem[0]);
    access(4'd4, 1'b0, 1'b0, q);
    chk("R9 cell 4 untouched", q, mem[4]);

    // R4 R5: refresh pass, then let rows 1..3 lapse while row 0 is restored
    for (int r = 0; r < 4; r++) begin
      activate(r[1:0]);
      precharge();
    end
    chk("R5 flags clear after refresh", decayed, 16'h0000);
    repeat (RET - 40) @(negedge clk);
    chk("R5 no early decay", decayed, 16'h0000);
    activate(2'd0);
    cas_op(2'd1, 1'b0, 1'b0, q);
    precharge();
    repeat (60) @(negedge clk);
    chk("R4 whole row 0 kept, rows 1-3 lapsed", decayed, 16'hFFF0);
    for (int i = 4; i < 16; i++) mem[i] = 1'b0;
    access(4'd3, 1'b0, 1'b0, q);
    chk("R4 unaccessed row-0 cell 3 kept", q, mem[3]);
    access(4'd7, 1'b0, 1'b0, q);
    chk("R5 lapsed cell 7 reads 0", q, 1'b0);
    chk("R5 row 1 flags cleared on restore", decayed[7:4], 4'h0);
    chk("R5 row 2 flags still set", decayed[11:8], 4'hF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule